// File: doc/BRIEF.md
# Forwarded-Clock Transaction Receiver

This block is the receive front end of a source-clocked serial link with five data wires and two forwarded clock wires, called A and B. No PLL recovers a clock. Each link clock drives two rows of capture registers, one on its rising edge and one on its falling edge. The four rows together capture a five-bit data group on every edge that a transaction uses. The framing decision is distributed across the rows. Each rising-edge row records the level of the opposite clock. Each falling-edge row reads those recorded levels, together with the live level of the other clock, to decide whether a transaction has ended and which kind it was.

A transaction ends only on a falling edge. It is then published as a 20-bit word plus a two-bit type code into a holding slot owned by that falling-edge row. There are two slots: one for results that end on the A falling edge and one for results that end on the B falling edge. A toggle request/acknowledge handshake with two-flop synchronisers carries each slot into the receiver clock domain. There the results are re-ordered into link completion order and presented as single-cycle valid pulses. A result that completes while its slot is still unacknowledged is dropped, and a sticky overrun flag is raised.

Top module: `fwdclk_txn_rx`

## Requirements
- R1: While rstN is low, and on the first receiver cycle after it rises, rxValid and rxOverrun are 0.
- R2: A CLEAR is one rise and one fall of A while B stays low. It is delivered with rxType 2'b01. rxWord[4:0] holds the group captured on the A rise, rxWord[9:5] holds the group captured on the A fall, and rxWord[19:10] is zero.
- R3: A STATUS is one rise and one fall of B while A stays low. It is delivered with rxType 2'b10. rxWord[4:0] holds the group captured on the B rise, rxWord[9:5] holds the group captured on the B fall, and rxWord[19:10] is zero.
- R4: A DATA transaction has four edges in this order: A rises, B rises, A falls, B falls. It is delivered with rxType 2'b00. rxWord holds the groups in edge order: [4:0] from the A rise, [9:5] from the B rise, [14:10] from the A fall, and [19:15] from the B fall.
- R5: An illegal edge order produces exactly one result with rxType 2'b11, and no other result for the same edges. Two orders are illegal:
  - B falls while A is high. The result has rxWord[4:0] = the B-rise group, rxWord[9:5] = the B-fall group, and the upper ten bits zero.
  - A rises while B is high. The result has rxWord[4:0] = the A-rise group, rxWord[9:5] = the A-fall group, and the upper ten bits zero.
- R6: Every transaction decodes from its own edges alone. This holds whatever came before it, including an illegal sequence.
- R7: Each accepted result appears exactly once, as a one-cycle rxValid pulse, with at most one result per receiver cycle. Results appear in the order in which their final falling edges occurred, even when results from both clocks become ready in the same receiver cycle.
- R8: Results that end on the A falling edge (CLEAR, and the A-rise error) share one slot. Results that end on the B falling edge (DATA, STATUS, and the B-fall error) share the other slot. A result that ends while its own slot is still unacknowledged is dropped, and rxOverrun rises and stays at 1 until reset. Later results are still delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rxClk | input | 1 | Receiver-domain clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| linkClkA | input | 1 | Forwarded link clock A |
| linkClkB | input | 1 | Forwarded link clock B |
| linkData | input | 5 | Link data group sampled on each used edge |
| rxValid | output | 1 | One-cycle pulse: a result is presented |
| rxType | output | 2 | 00 DATA, 01 CLEAR, 10 STATUS, 11 illegal |
| rxWord | output | 20 | Assembled payload, first edge in the low bits |
| rxOverrun | output | 1 | Sticky: a result was dropped |

## Verification
The two functions that can land in one receiver cycle are the request arrivals from the A-falling slot and the B-falling slot. In that case the order tags must choose the older result first. The bench provokes this by driving a CLEAR and a STATUS back to back, with their final falling edges under two nanoseconds apart, in both orders and at varied phases against the receiver clock. It judges the outcome by requiring the scoreboard's completion order exactly. A second collision puts a drop on one slot right beside a delivery from the same slot. The bench checks that the delivered word is intact and that the overrun flag rises.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int LANE_W = 5;
  localparam int WORD_W = 4 * LANE_W;
  localparam int SHORT_W = 2 * LANE_W;
  localparam int SEQ_W = 3;

  typedef enum logic [1:0] {
    TY_DATA    = 2'b00,
    TY_CLEAR   = 2'b01,
    TY_STATUS  = 2'b10,
    TY_ILLEGAL = 2'b11
  } txnType_e;

  // Decision strobes from the framing control to the capture rows.
  typedef struct packed {
    logic     swallowA;   // A fall: discard, the B row already reported
    logic     midA;       // A fall: middle of a DATA transaction
    logic     pubA;       // A fall: publish a result
    txnType_e typeA;
    logic     abortToB;   // A fall: tell B fall to discard
    logic     swallowB;
    logic     pubB;
    txnType_e typeB;
    logic     abortToA;
  } frameStrobe_t;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    txnType_e          kind;
    logic [SEQ_W-1:0]  otherCnt;  // results of the other slot published before this one
  } slot_t;
endpackage

// File: rtl/fcr_frame_ctl.sv
module fcr_frame_ctl
  import fcr_pkg::*;
(
  input  logic         clkALvl,
  input  logic         clkBLvl,
  input  logic         bAtARise,
  input  logic         aAtBRise,
  input  logic         abortPendA,
  input  logic         abortPendB,
  output frameStrobe_t strobe
);
  logic errA;
  logic errB;

  always_comb begin
    // Decisions taken at the falling edge of A
    errA            = !abortPendA && bAtARise;
    strobe.swallowA = abortPendA;
    strobe.midA     = !abortPendA && !bAtARise && clkBLvl;
    strobe.pubA     = !abortPendA && (bAtARise || !clkBLvl);
    strobe.typeA    = errA ? TY_ILLEGAL : TY_CLEAR;
    strobe.abortToB = errA && clkBLvl;
    // Decisions taken at the falling edge of B
    errB            = !abortPendB && clkALvl;
    strobe.swallowB = abortPendB;
    strobe.pubB     = !abortPendB;
    if (errB)          strobe.typeB = TY_ILLEGAL;
    else if (aAtBRise) strobe.typeB = TY_DATA;
    else               strobe.typeB = TY_STATUS;
    strobe.abortToA = errB;
  end
endmodule

// File: rtl/fcr_edge_rows.sv
module fcr_edge_rows
  import fcr_pkg::*;
(
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic [LANE_W-1:0] din,
  input  frameStrobe_t      strobe,
  input  logic [1:0]        ackTgl,
  output logic              bAtARise,
  output logic              aAtBRise,
  output logic              abortPendA,
  output logic              abortPendB,
  output slot_t [1:0]       slots,
  output logic [1:0]        reqTgl,
  output logic              ovf
);
  localparam int PAD_W = WORD_W - SHORT_W;

  logic [LANE_W-1:0] grpAR, grpBR, grpAF;
  slot_t             slotA, slotB;
  logic              reqA, reqB, ovfA, ovfB;
  logic [SEQ_W-1:0]  cntA, cntB;
  logic              abortAtoB, abortBtoA, seenAtoB, seenBtoA;

  // Row 1: rising edge of A
  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      grpAR    <= '0;
      bAtARise <= 1'b0;
    end else begin
      grpAR    <= din;
      bAtARise <= clkB;
    end
  end

  // Row 2: rising edge of B
  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      grpBR    <= '0;
      aAtBRise <= 1'b0;
    end else begin
      grpBR    <= din;
      aAtBRise <= clkA;
    end
  end

  // Row 3: falling edge of A, framing end and publish
  always_ff @(negedge clkA or negedge rstN) begin
    if (!rstN) begin
      grpAF     <= '0;
      slotA     <= '0;
      reqA      <= 1'b0;
      ovfA      <= 1'b0;
      cntA      <= '0;
      abortAtoB <= 1'b0;
      seenBtoA  <= 1'b0;
    end else begin
      if (strobe.swallowA) seenBtoA <= abortBtoA;
      if (strobe.midA) grpAF <= din;
      if (strobe.abortToB) abortAtoB <= ~abortAtoB;
      if (strobe.pubA) begin
        if (reqA != ackTgl[0]) begin
          ovfA <= 1'b1;
        end else begin
          slotA.word     <= {{PAD_W{1'b0}}, din, grpAR};
          slotA.kind     <= strobe.typeA;
          slotA.otherCnt <= cntB;
          reqA           <= ~reqA;
          cntA           <= cntA + 1'b1;
        end
      end
    end
  end

  // Row 4: falling edge of B, framing end and publish
  always_ff @(negedge clkB or negedge rstN) begin
    if (!rstN) begin
      slotB     <= '0;
      reqB      <= 1'b0;
      ovfB      <= 1'b0;
      cntB      <= '0;
      abortBtoA <= 1'b0;
      seenAtoB  <= 1'b0;
    end else begin
      if (strobe.swallowB) seenAtoB <= abortAtoB;
      if (strobe.abortToA) abortBtoA <= ~abortBtoA;
      if (strobe.pubB) begin
        if (reqB != ackTgl[1]) begin
          ovfB <= 1'b1;
        end else begin
          if (strobe.typeB == TY_DATA)
            slotB.word <= {din, grpAF, grpBR, grpAR};
          else
            slotB.word <= {{PAD_W{1'b0}}, din, grpBR};
          slotB.kind     <= strobe.typeB;
          slotB.otherCnt <= cntA;
          reqB           <= ~reqB;
          cntB           <= cntB + 1'b1;
        end
      end
    end
  end

  assign abortPendA = abortBtoA != seenBtoA;
  assign abortPendB = abortAtoB != seenAtoB;
  assign slots      = {slotB, slotA};
  assign reqTgl     = {reqB, reqA};
  assign ovf        = ovfA | ovfB;
endmodule

// File: rtl/fcr_rx_handoff.sv
module fcr_rx_handoff
  import fcr_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              rxClk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqTgl,
  input  slot_t [NUM_CH-1:0] slots,
  input  logic              ovfIn,
  output logic              rxValid,
  output txnType_e          rxType,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxOverrun,
  output logic [NUM_CH-1:0] ackTgl
);
  logic [NUM_CH-1:0] reqS1, reqS2, pend, elig;
  logic [SEQ_W-1:0]  delCnt [NUM_CH];
  logic              ovfS1, ovfS2;
  logic              anyPick;
  logic              pickIdx;

  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN) begin
      reqS1 <= '0;
      reqS2 <= '0;
      ovfS1 <= 1'b0;
      ovfS2 <= 1'b0;
    end else begin
      reqS1 <= reqTgl;
      reqS2 <= reqS1;
      ovfS1 <= ovfIn;
      ovfS2 <= ovfS1;
    end
  end

  // A slot may go only once every older result of the other slot is delivered.
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign pend[c] = reqS2[c] ^ ackTgl[c];
      assign elig[c] = pend[c] && (slots[c].otherCnt == delCnt[NUM_CH-1-c]);
    end
  endgenerate

  always_comb begin
    anyPick = |elig;
    pickIdx = elig[0] ? 1'b0 : 1'b1;
  end

  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxType  <= TY_DATA;
      rxWord  <= '0;
      ackTgl  <= '0;
      for (int i = 0; i < NUM_CH; i++) delCnt[i] <= '0;
    end else begin
      rxValid <= anyPick;
      if (anyPick) begin
        rxWord          <= slots[pickIdx].word;
        rxType          <= slots[pickIdx].kind;
        ackTgl[pickIdx] <= ~ackTgl[pickIdx];
        delCnt[pickIdx] <= delCnt[pickIdx] + 1'b1;
      end
    end
  end

  assign rxOverrun = ovfS2;
endmodule

// File: rtl/fwdclk_txn_rx.sv
module fwdclk_txn_rx
  import fcr_pkg::*;
(
  input  logic              rxClk,
  input  logic              rstN,
  input  logic              linkClkA,
  input  logic              linkClkB,
  input  logic [LANE_W-1:0] linkData,
  output logic              rxValid,
  output logic [1:0]        rxType,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxOverrun
);
  frameStrobe_t strobe;
  slot_t [1:0]  slots;
  logic [1:0]   reqTgl, ackTgl;
  logic         bAtARise, aAtBRise, abortPendA, abortPendB, ovf;
  txnType_e     rxTypeE;

  fcr_frame_ctl u_ctl (
    .clkALvl(linkClkA), .clkBLvl(linkClkB),
    .bAtARise(bAtARise), .aAtBRise(aAtBRise),
    .abortPendA(abortPendA), .abortPendB(abortPendB),
    .strobe(strobe)
  );

  fcr_edge_rows u_rows (
    .clkA(linkClkA), .clkB(linkClkB), .rstN(rstN), .din(linkData),
    .strobe(strobe), .ackTgl(ackTgl),
    .bAtARise(bAtARise), .aAtBRise(aAtBRise),
    .abortPendA(abortPendA), .abortPendB(abortPendB),
    .slots(slots), .reqTgl(reqTgl), .ovf(ovf)
  );

  fcr_rx_handoff #(.NUM_CH(2)) u_hand (
    .rxClk(rxClk), .rstN(rstN), .reqTgl(reqTgl), .slots(slots), .ovfIn(ovf),
    .rxValid(rxValid), .rxType(rxTypeE), .rxWord(rxWord),
    .rxOverrun(rxOverrun), .ackTgl(ackTgl)
  );

  assign rxType = rxTypeE;
endmodule

// File: rtl/fwdclk_txn_rx_chk.sv
module fwdclk_txn_rx_chk (
  input logic        rxClk,
  input logic        rstN,
  input logic        rxValid,
  input logic [1:0]  rxType,
  input logic [19:0] rxWord,
  input logic        rxOverrun,
  input logic [1:0]  ackTgl
);
  AST_ONE_RESULT_PER_CYCLE: assert property (@(posedge rxClk) disable iff (!rstN)
    $onehot0(ackTgl ^ $past(ackTgl))); // R7
  AST_VALID_MATCHES_ACK: assert property (@(posedge rxClk) disable iff (!rstN)
    rxValid |-> $countones(ackTgl ^ $past(ackTgl)) == 1); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge rxClk) disable iff (!rstN)
    rxOverrun |=> rxOverrun); // R8
  AST_SHORT_UPPER_ZERO: assert property (@(posedge rxClk) disable iff (!rstN)
    (rxValid && rxType != 2'b00) |-> rxWord[19:10] == 10'd0); // R2
  AST_VALID_KNOWN: assert property (@(posedge rxClk) disable iff (!rstN)
    rxValid |-> !$isunknown({rxType, rxWord})); // R4
endmodule

bind fwdclk_txn_rx fwdclk_txn_rx_chk u_chk (
  .rxClk(rxClk), .rstN(rstN), .rxValid(rxValid), .rxType(rxType),
  .rxWord(rxWord), .rxOverrun(rxOverrun), .ackTgl(ackTgl)
);

// File: tb/fwdclk_txn_rx_bench.sv
`timescale 1ns/1ps
module fwdclk_txn_rx_bench;
  logic        rxClk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkClkA = 1'b0;
  logic        linkClkB = 1'b0;
  logic [4:0]  linkData = '0;
  logic        rxValid;
  logic [1:0]  rxType;
  logic [19:0] rxWord;
  logic        rxOverrun;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [1:0]  expTy[$];
  logic [19:0] expW[$];
  string       expTag[$];

  fwdclk_txn_rx u_fwdclk_txn_rx (.*);

  always #2 rxClk = ~rxClk;

  function automatic logic [19:0] shortWord(logic [4:0] first, logic [4:0] second);
    return {10'd0, second, first};
  endfunction

  task automatic expect1(logic [1:0] ty, logic [19:0] w, string tag);
    expTy.push_back(ty);
    expW.push_back(w);
    expTag.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard: results in completion order
  always @(negedge rxClk) begin
    if (rstN && rxValid && !done) begin
      if (expTy.size() == 0) begin
        check(0, "R7 unexpected result", {10'd0, rxType, rxWord}, 32'h0);
      end else begin
        logic [1:0] ty;
        logic [19:0] w;
        string tag;
        ty = expTy.pop_front();
        w = expW.pop_front();
        tag = expTag.pop_front();
        check(rxType == ty && rxWord == w, tag, {10'd0, rxType, rxWord}, {10'd0, ty, w});
      end
    end
  end

  task automatic setClk(bit onA, bit v);
    if (onA) linkClkA = v; else linkClkB = v;
  endtask

  task automatic step(bit onA, bit v, logic [4:0] d);
    linkData = d;
    #(2 + $urandom % 3);
    setClk(onA, v);
    #(2 + $urandom % 4);
  endtask

  task automatic gap();
    #(60 + $urandom % 40);
  endtask

  task automatic sendClear(logic [4:0] d0, logic [4:0] d1, string tag);
    expect1(2'b01, shortWord(d0, d1), tag);
    step(1, 1, d0); step(1, 0, d1);
  endtask

  task automatic sendStatus(logic [4:0] d0, logic [4:0] d1, string tag);
    expect1(2'b10, shortWord(d0, d1), tag);
    step(0, 1, d0); step(0, 0, d1);
  endtask

  task automatic sendData(logic [4:0] d0, logic [4:0] d1, logic [4:0] d2, logic [4:0] d3, string tag);
    expect1(2'b00, {d3, d2, d1, d0}, tag);
    step(1, 1, d0); step(0, 1, d1); step(1, 0, d2); step(0, 0, d3);
  endtask

  // B falls while A still high
  task automatic sendErrBEarly(logic [4:0] d0, logic [4:0] d1, logic [4:0] d2, logic [4:0] d3, string tag);
    expect1(2'b11, shortWord(d1, d2), tag);
    step(1, 1, d0); step(0, 1, d1); step(0, 0, d2); step(1, 0, d3);
  endtask

  // A rises while B high
  task automatic sendErrARise(logic [4:0] d0, logic [4:0] d1, logic [4:0] d2, logic [4:0] d3, string tag);
    expect1(2'b11, shortWord(d1, d2), tag);
    step(0, 1, d0); step(1, 1, d1); step(1, 0, d2); step(0, 0, d3);
  endtask

  // Two short transactions ending about 1.6 ns apart
  task automatic fastPair(bit aFirst, logic [4:0] d0, logic [4:0] d1, logic [4:0] d2, logic [4:0] d3);
    if (aFirst) begin
      expect1(2'b01, shortWord(d0, d1), "R7 same-cycle CLEAR first");
      expect1(2'b10, shortWord(d2, d3), "R7 same-cycle STATUS second");
    end else begin
      expect1(2'b10, shortWord(d0, d1), "R7 same-cycle STATUS first");
      expect1(2'b01, shortWord(d2, d3), "R7 same-cycle CLEAR second");
    end
    #(($urandom % 40) / 10.0);
    linkData = d0; #0.5;
    setClk(aFirst, 1); #0.4 linkData = d1; #0.4;
    setClk(aFirst, 0); #0.4 linkData = d2; #0.4;
    setClk(!aFirst, 1); #0.4 linkData = d3; #0.4;
    setClk(!aFirst, 0); #1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      check(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge rxClk);
    @(negedge rxClk);
    check(rxValid == 0, "R1 valid in reset", rxValid, 0);
    check(rxOverrun == 0, "R1 overrun in reset", rxOverrun, 0);
    rstN = 1'b1;
    @(negedge rxClk);
    check(rxValid == 0, "R1 valid after reset", rxValid, 0);
    gap();

    // Directed cases
    sendClear(5'h15, 5'h0a, "R2 CLEAR");            gap();
    sendStatus(5'h1f, 5'h01, "R3 STATUS");          gap();
    sendData(5'h01, 5'h02, 5'h04, 5'h18, "R4 DATA"); gap();
    sendErrBEarly(5'h03, 5'h0c, 5'h11, 5'h1e, "R5 B falls with A high"); gap();
    sendClear(5'h07, 5'h19, "R6 CLEAR after illegal"); gap();
    sendErrARise(5'h05, 5'h12, 5'h1d, 5'h08, "R5 A rises with B high"); gap();
    sendStatus(5'h0e, 5'h13, "R6 STATUS after illegal"); gap();

    // Both slots ready in the same receiver cycle, both orders
    for (int i = 0; i < 6; i++) begin
      fastPair(i[0], 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      gap();
    end

    // Constrained random mix
    for (int i = 0; i < 80; i++) begin
      logic [4:0] d0, d1, d2, d3;
      d0 = 5'($urandom); d1 = 5'($urandom); d2 = 5'($urandom); d3 = 5'($urandom);
      case ($urandom % 6)
        0: sendClear(d0, d1, "R6 random CLEAR");
        1: sendStatus(d0, d1, "R6 random STATUS");
        2, 3: sendData(d0, d1, d2, d3, "R6 random DATA");
        4: sendErrBEarly(d0, d1, d2, d3, "R6 random B-early");
        default: sendErrARise(d0, d1, d2, d3, "R6 random A-rise");
      endcase
      gap();
    end

    @(negedge rxClk);
    check(rxOverrun == 0, "R8 no overrun with spacing", rxOverrun, 0);

    // Overrun: second CLEAR ends before the first is acknowledged
    expect1(2'b01, shortWord(5'h09, 5'h16), "R8 first CLEAR kept");
    linkData = 5'h09; #0.5 linkClkA = 1; #0.5 linkData = 5'h16; #0.5 linkClkA = 0;
    #0.5 linkData = 5'h1b; #0.5 linkClkA = 1; #0.5 linkData = 5'h04; #0.5 linkClkA = 0;
    gap();
    @(negedge rxClk);
    check(rxOverrun == 1, "R8 overrun raised", rxOverrun, 1);
    sendClear(5'h0d, 5'h1a, "R8 CLEAR after overrun"); gap();
    sendData(5'h11, 5'h06, 5'h1c, 5'h0b, "R8 DATA after overrun"); gap();
    @(negedge rxClk);
    check(rxOverrun == 1, "R8 overrun sticky", rxOverrun, 1);

    #300;
    check(expTy.size() == 0, "R7 all results delivered", expTy.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule